// File: doc/BRIEF.md
# Host Wake and Access Handshake

This block holds the power-state control and status registers that a host sees over a plain single-cycle register port. It decides when the internal core is powered and when other blocks may reach internal resources. The host sets an init-done bit to bring the core up for the first time. After that it holds an access request to keep the core awake. When nothing asks for the core, the block lets it idle, announces that it is going to sleep, and then powers it down. A parameterised wake latency and sleep latency stand in for the analog power sequencing.

The register port has no back-pressure. Every write is accepted in the cycle it is presented. Read data is combinational from the current address and reflects the register state after the most recent clock edge. Two word addresses are decoded: the general control word (default index 9) and the reset control word (default index 8). The two outputs that other blocks use are `core_pwr_en_o`, which keeps the core supply on, and `access_ok_o`, which qualifies indirect access into the core. The registers stay usable while the core is off.

Top module: `wake_access_ctrl`

## Requirements
- R1: After reset, the general control word (index 9) and the reset control word (index 8) both read 0, and `core_pwr_en_o`, `access_ok_o` and `master_off_o` are all 0.
- R2: Clock-ready (general control bit 0) and `core_pwr_en_o` stay 0 while init-done (bit 2) is 0, even when the access request (bit 3) is set.
- R3: Take the clock edge that writes init-done from 0 to 1. `core_pwr_en_o` rises on the next edge, and clock-ready rises WAKE_LAT+1 edges after the write edge.
- R4: `access_ok_o` is 1 only while the access request, clock-ready and a cleared going-to-sleep (bit 4) hold together.
- R5: When init-done is 1, the request is 0 and the core is awake, going-to-sleep rises IDLE_CYC edges after the last edge that saw a request or wake completion. Clock-ready stays 1 for SLEEP_LAT edges and then falls, together with going-to-sleep and `core_pwr_en_o`. A held request prevents sleep.
- R6: A request that is seen while going-to-sleep is set aborts the sleep on the next edge. Clock-ready stays 1 and going-to-sleep clears.
- R7: After a completed sleep, the core wakes again only on an access request. The same WAKE_LAT+1 edge timing applies, counted from the write edge.
- R8: Bits 26:24 give the power-save mode. The value 000 is set when a wake completes. After a sleep the value is 001 if `radio_pd_i` is 0 at completion, or 010 if it is 1. The value 011 is set when a write leaves the request at 1 with init-done at 0.
- R9: Writing init-done to 0 while the core is powered turns off `core_pwr_en_o` and clock-ready one edge after the write edge.
- R10: Writing 1 to reset-control bit 7 clears init-done, the request and the power-save mode on that edge, and powers the core off on that same edge. Bit 7 always reads 0.
- R11: Reset-control bit 9 is a stop request that the host can read back. Master-disabled (bit 8) and `master_off_o` follow it one edge later.
- R12: Writes to read-only bits (0, 4, 8 and 26:24) have no effect. Unmapped addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe, accepted in the same cycle |
| reg_addr_i | input | ADDR_W | Register word index |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data for reg_addr_i |
| radio_pd_i | input | 1 | Radio power-down indication, selects mode 010 at sleep completion |
| core_pwr_en_o | output | 1 | Core power enable |
| access_ok_o | output | 1 | Internal access granted qualifier |
| master_off_o | output | 1 | Bus master disabled status |

## Verification
Every cycle, the assertions check the following rules:
- access is granted only while the core is powered;
- clock-ready rises only after init-done was set;
- master-disabled trails the stop request by one edge;
- a software reset leaves the control bits clear;
- a request seen during going-to-sleep brings the core back to awake;
- going-to-sleep starts only from an awake, unrequested core.

The exact latencies (WAKE_LAT+1 to clock-ready, IDLE_CYC to going-to-sleep, SLEEP_LAT to power-off) can be shown only by the bench's scenarios. The same holds for the power-save mode codes, re-wake by request alone, and the handling of read-only bits and unmapped addresses. Those scenarios run against a cycle-accurate reference model.

// File: rtl/wak_pkg.sv
package wak_pkg;

  typedef enum logic [1:0] {
    PW_OFF      = 2'd0,
    PW_WAKING   = 2'd1,
    PW_AWAKE    = 2'd2,
    PW_SLEEPING = 2'd3
  } pw_state_e;

  typedef enum logic [2:0] {
    PS_NONE  = 3'd0,
    PS_CORE  = 3'd1,
    PS_RADIO = 3'd2,
    PS_ERR   = 3'd3
  } ps_mode_e;

  // general control word bit positions
  localparam int GC_RDY   = 0;
  localparam int GC_INIT  = 2;
  localparam int GC_REQ   = 3;
  localparam int GC_GTS   = 4;
  localparam int GC_PS_LO = 24;

  // reset control word bit positions
  localparam int RS_SWRST = 7;
  localparam int RS_MDIS  = 8;
  localparam int RS_STOP  = 9;

endpackage

// File: rtl/wak_master_stop.sv
module wak_master_stop #(
  parameter int STOP_DLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_q_i,
  output logic mdis_o
);

  logic [STOP_DLY-1:0] pipe_q;

  generate
    if (STOP_DLY == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= stop_q_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STOP_DLY-2:0], stop_q_i};
      end
    end
  endgenerate

  assign mdis_o = pipe_q[STOP_DLY-1];

endmodule

// File: rtl/wak_pwr_fsm.sv
module wak_pwr_fsm
  import wak_pkg::*;
#(
  parameter int WAKE_LAT  = 5,
  parameter int SLEEP_LAT = 4,
  parameter int IDLE_CYC  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_rst_i,
  input  logic init_q_i,
  input  logic req_q_i,
  output logic clk_rdy_o,
  output logic gts_o,
  output logic pwr_en_o,
  output logic ev_awake_o,
  output logic ev_slept_o
);

  localparam int MAX_WS  = (WAKE_LAT > SLEEP_LAT) ? WAKE_LAT : SLEEP_LAT;
  localparam int CNT_MAX = (MAX_WS > IDLE_CYC) ? MAX_WS : IDLE_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] WAKE_END  = CW'(WAKE_LAT - 1);
  localparam logic [CW-1:0] SLEEP_END = CW'(SLEEP_LAT - 1);
  localparam logic [CW-1:0] IDLE_END  = CW'(IDLE_CYC - 1);

  pw_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic boot_q, boot_d;
  logic ev_awake, ev_slept;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    ev_awake = 1'b0;
    ev_slept = 1'b0;
    if (sw_rst_i) begin
      st_d  = PW_OFF;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        PW_OFF: begin
          if (init_q_i && (req_q_i || boot_q)) begin
            st_d  = PW_WAKING;
            cnt_d = '0;
          end
        end
        PW_WAKING: begin
          if (!init_q_i) begin
            st_d = PW_OFF;
          end else if (cnt_q == WAKE_END) begin
            st_d     = PW_AWAKE;
            cnt_d    = '0;
            ev_awake = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PW_AWAKE: begin
          if (!init_q_i) begin
            st_d = PW_OFF;
          end else if (req_q_i) begin
            cnt_d = '0;
          end else if (cnt_q == IDLE_END) begin
            st_d  = PW_SLEEPING;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PW_SLEEPING: begin
          if (!init_q_i) begin
            st_d = PW_OFF;
          end else if (req_q_i) begin
            st_d  = PW_AWAKE;
            cnt_d = '0;
          end else if (cnt_q == SLEEP_END) begin
            st_d     = PW_OFF;
            cnt_d    = '0;
            ev_slept = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = PW_OFF;
      endcase
    end
  end

  // first wake after init-done needs no request; re-armed whenever init-done is low
  always_comb begin
    if (sw_rst_i || !init_q_i) boot_d = 1'b1;
    else if (ev_awake)         boot_d = 1'b0;
    else                       boot_d = boot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PW_OFF;
      cnt_q  <= '0;
      boot_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      boot_q <= boot_d;
    end
  end

  assign clk_rdy_o  = (st_q == PW_AWAKE) || (st_q == PW_SLEEPING);
  assign gts_o      = (st_q == PW_SLEEPING);
  assign pwr_en_o   = (st_q != PW_OFF);
  assign ev_awake_o = ev_awake;
  assign ev_slept_o = ev_slept;

endmodule

// File: rtl/wak_regs.sv
module wak_regs
  import wak_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int GCTL_IDX = 9,
  parameter int RST_IDX  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              radio_pd_i,
  input  logic              clk_rdy_i,
  input  logic              gts_i,
  input  logic              mdis_i,
  input  logic              ev_awake_i,
  input  logic              ev_slept_i,
  output logic              init_q_o,
  output logic              req_q_o,
  output logic              stop_q_o,
  output logic              sw_rst_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [ADDR_W-1:0] A_GCTL = ADDR_W'(GCTL_IDX);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(RST_IDX);

  logic wr_gctl, wr_rst;
  logic init_q, req_q, stop_q;
  ps_mode_e ps_q;
  logic unused_wdata;

  assign wr_gctl  = we_i && (addr_i == A_GCTL);
  assign wr_rst   = we_i && (addr_i == A_RST);
  assign sw_rst_o = wr_rst && wdata_i[RS_SWRST];
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      req_q  <= 1'b0;
      stop_q <= 1'b0;
      ps_q   <= PS_NONE;
    end else begin
      if (wr_rst) stop_q <= wdata_i[RS_STOP];
      if (sw_rst_o) begin
        init_q <= 1'b0;
        req_q  <= 1'b0;
        ps_q   <= PS_NONE;
      end else begin
        if (ev_slept_i)      ps_q <= radio_pd_i ? PS_RADIO : PS_CORE;
        else if (ev_awake_i) ps_q <= PS_NONE;
        if (wr_gctl) begin
          init_q <= wdata_i[GC_INIT];
          req_q  <= wdata_i[GC_REQ];
          if (wdata_i[GC_REQ] && !wdata_i[GC_INIT]) ps_q <= PS_ERR;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_GCTL) begin
      rdata_o[GC_RDY]          = clk_rdy_i;
      rdata_o[GC_INIT]         = init_q;
      rdata_o[GC_REQ]          = req_q;
      rdata_o[GC_GTS]          = gts_i;
      rdata_o[GC_PS_LO +: 3]   = ps_q;
    end else if (addr_i == A_RST) begin
      rdata_o[RS_MDIS] = mdis_i;
      rdata_o[RS_STOP] = stop_q;
    end
  end

  assign init_q_o = init_q;
  assign req_q_o  = req_q;
  assign stop_q_o = stop_q;

endmodule

// File: rtl/wake_access_ctrl.sv
module wake_access_ctrl #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int GCTL_IDX  = 9,
  parameter int RST_IDX   = 8,
  parameter int WAKE_LAT  = 5,
  parameter int SLEEP_LAT = 4,
  parameter int IDLE_CYC  = 6,
  parameter int STOP_DLY  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              radio_pd_i,
  output logic              core_pwr_en_o,
  output logic              access_ok_o,
  output logic              master_off_o
);

  logic init_q, req_q, stop_q, sw_rst_hit;
  logic clk_rdy, gts, ev_awake, ev_slept, mdis;

  wak_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GCTL_IDX(GCTL_IDX), .RST_IDX(RST_IDX)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .radio_pd_i(radio_pd_i),
    .clk_rdy_i(clk_rdy), .gts_i(gts), .mdis_i(mdis),
    .ev_awake_i(ev_awake), .ev_slept_i(ev_slept),
    .init_q_o(init_q), .req_q_o(req_q), .stop_q_o(stop_q),
    .sw_rst_o(sw_rst_hit), .rdata_o(reg_rdata_o)
  );

  wak_pwr_fsm #(
    .WAKE_LAT(WAKE_LAT), .SLEEP_LAT(SLEEP_LAT), .IDLE_CYC(IDLE_CYC)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sw_rst_i(sw_rst_hit), .init_q_i(init_q), .req_q_i(req_q),
    .clk_rdy_o(clk_rdy), .gts_o(gts), .pwr_en_o(core_pwr_en_o),
    .ev_awake_o(ev_awake), .ev_slept_o(ev_slept)
  );

  wak_master_stop #(.STOP_DLY(STOP_DLY)) u_mstop (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_q_i(stop_q), .mdis_o(mdis)
  );

  assign access_ok_o  = req_q & clk_rdy & ~gts;
  assign master_off_o = mdis;

endmodule

// File: rtl/wake_access_ctrl_chk.sv
module wake_access_ctrl_chk #(
  parameter int STOP_DLY = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr,
  input logic ok,
  input logic mdis,
  input logic clk_rdy,
  input logic gts,
  input logic init_q,
  input logic req_q,
  input logic stop_q,
  input logic sw_rst
);

  assert_ok_needs_power_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok |-> pwr);

  assert_ready_after_init_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_rdy) |-> $past(init_q));

  assert_swrst_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst |=> (!init_q && !req_q && !pwr && !clk_rdy));

  assert_abort_sleep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gts && req_q && init_q && !sw_rst) |=> (clk_rdy && !gts));

  assert_sleep_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gts) |-> ($past(clk_rdy) && !$past(req_q) && $past(init_q)));

  generate
    if (STOP_DLY == 1) begin : g_mdis
      assert_mdis_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mdis == $past(stop_q));
    end
  endgenerate

endmodule

bind wake_access_ctrl wake_access_ctrl_chk #(.STOP_DLY(STOP_DLY)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr(core_pwr_en_o), .ok(access_ok_o),
  .mdis(master_off_o), .clk_rdy(clk_rdy), .gts(gts), .init_q(init_q),
  .req_q(req_q), .stop_q(stop_q), .sw_rst(sw_rst_hit)
);

// File: tb/sim_wake_access_ctrl.sv
`timescale 1ns/1ps
module sim_wake_access_ctrl;
  localparam int WL = 5, SL = 4, IC = 6;
  localparam int G = 9, R = 8;
  localparam int WD_LIM = 100000;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, radio = 1'b0;
  logic [3:0] addr = 4'(G);
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic pwr, ok, moff;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_st = 0, m_cnt = 0, m_boot = 1, m_init = 0, m_req = 0, m_ps = 0, m_stop = 0, m_mdis = 0;

  always #2.5 clk = ~clk;

  wake_access_ctrl #(.GCTL_IDX(G), .RST_IDX(R), .WAKE_LAT(WL), .SLEEP_LAT(SL), .IDLE_CYC(IC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd),
    .reg_rdata_o(rd), .radio_pd_i(radio), .core_pwr_en_o(pwr), .access_ok_o(ok),
    .master_off_o(moff));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // reference model, stepped on every clock edge, compared 1 ns later
  always @(posedge clk) begin
    int o_init, o_req, o_stop, o_st, ea, es, wg, wr, swr, exp_rd;
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_boot = 1; m_init = 0; m_req = 0; m_ps = 0; m_stop = 0; m_mdis = 0;
    end else begin
      o_init = m_init; o_req = m_req; o_stop = m_stop; o_st = m_st; ea = 0; es = 0;
      wg = (we && addr == 4'(G)) ? 1 : 0;
      wr = (we && addr == 4'(R)) ? 1 : 0;
      swr = (wr != 0 && wd[7]) ? 1 : 0;
      m_mdis = o_stop;
      if (wr != 0) m_stop = int'(wd[9]);
      if (swr != 0) begin
        m_st = 0; m_cnt = 0; m_init = 0; m_req = 0; m_ps = 0; m_boot = 1;
      end else begin
        case (o_st)
          0: if (o_init != 0 && (o_req != 0 || m_boot != 0)) begin m_st = 1; m_cnt = 0; end
          1: if (o_init == 0) m_st = 0;
             else if (m_cnt == WL-1) begin m_st = 2; m_cnt = 0; ea = 1; end
             else m_cnt++;
          2: if (o_init == 0) m_st = 0;
             else if (o_req != 0) m_cnt = 0;
             else if (m_cnt == IC-1) begin m_st = 3; m_cnt = 0; end
             else m_cnt++;
          default: if (o_init == 0) m_st = 0;
             else if (o_req != 0) begin m_st = 2; m_cnt = 0; end
             else if (m_cnt == SL-1) begin m_st = 0; m_cnt = 0; es = 1; end
             else m_cnt++;
        endcase
        if (o_init == 0) m_boot = 1; else if (ea != 0) m_boot = 0;
        if (es != 0) m_ps = radio ? 2 : 1; else if (ea != 0) m_ps = 0;
        if (wg != 0) begin
          m_init = int'(wd[2]); m_req = int'(wd[3]);
          if (wd[3] && !wd[2]) m_ps = 3;
        end
      end
    end
    #1;
    if (rst_n) begin
      exp_rd = 0;
      if (addr == 4'(G))
        exp_rd = ((m_st >= 2) ? 1 : 0) | (m_init << 2) | (m_req << 3) | ((m_st == 3) ? 16 : 0) | (m_ps << 24);
      else if (addr == 4'(R))
        exp_rd = (m_mdis << 8) | (m_stop << 9);
      chk("R3/R5/R8/R12 model rdata", int'(rd), exp_rd);
      chk("R2/R9 model core_pwr_en", int'(pwr), (m_st != 0) ? 1 : 0);
      chk("R4 model access_ok", int'(ok), (m_req != 0 && m_st == 2) ? 1 : 0);
      chk("R11 model master_off", int'(moff), m_mdis);
    end
    if (cyc > WD_LIM) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WD_LIM);
      finish_run();
    end
  end

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 4'(a); wd = d;
    @(negedge clk); we = 1'b0; addr = 4'(G); wd = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // count negedges until bit 0 (clock-ready) of the general word reaches val
  task automatic wait_rdy(int val, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (int'(rd[0]) != val && n < 60);
  endtask

  initial begin
    int n;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gctl after reset", int'(rd), 0);
    chk("R1 outputs after reset", int'({pwr, ok, moff}), 0);
    addr = 4'(R); #0.1;
    chk("R1 rst word after reset", int'(rd), 0);
    addr = 4'(G);

    // request without init-done
    wr_reg(G, 32'h8);
    idle(10);
    chk("R2 no clock-ready without init", int'(rd[0]), 0);
    chk("R2 no power without init", int'(pwr), 0);
    chk("R8 error mode 011", int'(rd[26:24]), 3);

    // first wake by init-done alone
    wr_reg(G, 32'h4);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) chk("R3 power on edge after write", int'(pwr), 1);
    end while (!rd[0] && n < 60);
    chk("R3 clock-ready latency", n, WL + 1);
    chk("R8 mode 000 when awake", int'(rd[26:24]), 0);

    // idle to sleep, then power-off
    n = 0;
    do begin @(negedge clk); n++; end while (!rd[4] && n < 60);
    chk("R5 idle cycles to going-to-sleep", n, IC);
    chk("R4 no access while sleeping", int'(ok), 0);
    wait_rdy(0, n);
    chk("R5 sleep latency", n, SL);
    chk("R5 power off after sleep", int'(pwr), 0);
    chk("R8 mode 001 after sleep", int'(rd[26:24]), 1);

    // re-wake only by request
    idle(10);
    chk("R7 stays off without request", int'(pwr), 0);
    wr_reg(G, 32'hC);
    wait_rdy(1, n);
    chk("R7 re-wake latency", n, WL + 1);
    chk("R4 access granted", int'(ok), 1);
    idle(IC + 5);
    chk("R5 held request blocks sleep", int'(rd[4]), 0);

    // abort of a sleep
    wr_reg(G, 32'h4);
    n = 0;
    do begin @(negedge clk); n++; end while (!rd[4] && n < 60);
    chk("R5 going-to-sleep after request drop", n, IC);
    wr_reg(G, 32'hC);
    chk("R4 no access while going-to-sleep", int'(ok), 0);
    @(negedge clk);
    chk("R6 abort clears going-to-sleep", int'(rd[4]), 0);
    chk("R6 clock-ready kept", int'(rd[0]), 1);
    chk("R6 access after abort", int'(ok), 1);

    // radio power-down mode
    radio = 1'b1;
    wr_reg(G, 32'h4);
    n = 0;
    do begin @(negedge clk); n++; end while (pwr && n < 60);
    chk("R8 mode 010 with radio down", int'(rd[26:24]), 2);
    radio = 1'b0;

    // clearing init-done
    wr_reg(G, 32'hC);
    wait_rdy(1, n);
    wr_reg(G, 32'h0);
    @(negedge clk);
    chk("R9 power off after init clear", int'(pwr), 0);
    chk("R9 clock-ready off after init clear", int'(rd[0]), 0);

    // stop master
    wr_reg(R, 32'h200);
    chk("R11 master_off not yet", int'(moff), 0);
    @(negedge clk);
    chk("R11 master_off one edge later", int'(moff), 1);
    addr = 4'(R); #0.1;
    chk("R11 rst word readback", int'(rd), 32'h300);
    addr = 4'(G);
    wr_reg(R, 32'h0);
    @(negedge clk);
    chk("R11 master_off released", int'(moff), 0);

    // software reset while awake
    wr_reg(G, 32'hC);
    wait_rdy(1, n);
    wr_reg(R, 32'h80);
    chk("R10 gctl cleared", int'(rd), 0);
    chk("R10 power off", int'(pwr), 0);
    addr = 4'(R); #0.1;
    chk("R10 reset bit reads 0", int'(rd[7]), 0);
    addr = 4'(G);
    idle(10);
    chk("R2 no wake after software reset", int'(rd[0]), 0);

    // read-only bits and unmapped addresses
    wr_reg(G, 32'hFFFF_FFF3);
    chk("R12 read-only gctl bits", int'(rd), 0);
    wr_reg(3, 32'hFFFF_FFFF);
    addr = 4'(3); #0.1;
    chk("R12 unmapped reads 0", int'(rd), 0);
    addr = 4'(G);
    wr_reg(R, 32'h100);
    idle(2);
    chk("R12 master-disabled not writable", int'(moff), 0);
    chk("R12 no side effect on power", int'(pwr), 0);

    idle(3);
    finish_run();
  end
endmodule